// File: doc/BRIEF.md
# Reset Qualification and Vector Sequencer

This block stands between a raw active-low reset pin and a processor core. It passes the pin through a synchronizer and measures how long the synchronized level stays low. A low period shorter than a minimum length is treated as a glitch. Such a pulse stops the core only while it lasts. A low period that reaches the minimum is a qualified reset. It drives a peripheral-reset broadcast until the pin goes high again.

When the pin is released after a qualified reset, the block runs a fixed start-up sequence. First it forces the interrupt mask bit to 1. It then reads two bytes from a byte-wide synchronous memory port at the vector address and the address after it. It joins the two bytes into a 16-bit start address and loads that into the program counter. In the same cycle it releases halt and raises a one-cycle done flag.

Top module: `rst_vec_seq`

## Requirements
- R1: `halt` is 1 during every cycle in which the synchronized pin is low. It is also 1 from a qualified reset until the cycle in which the program counter is loaded.
- R2: A low period of at least `MIN_LOW` (default 10) clock cycles on `rst_pin_n` is accepted. After release it produces exactly one start-up sequence.
- R3: A low period shorter than `MIN_LOW` cycles is ignored. There is no `periph_rst`, no `boot_done` and no change to `pc`, and `halt` drops again after the pulse.
- R4: The low-time count clears whenever the synchronized pin returns high. Two short low periods split by one high cycle are not added together and do not qualify.
- R5: `periph_rst` is 1 while a qualified reset is held and 0 in all other cycles, including before qualification.
- R6: `imask` is 1 before the first vector read is issued, and it stays 1 after the sequence.
- R7: The vector reads are two single-cycle reads, each with `mem_rd`=1. Address `VEC_ADDR` (default 0x0000) comes in one cycle and `VEC_ADDR`+1 in the next. Data returns on `mem_rdata` in the cycle after its address.
- R8: With `BIG_END`=1 (default), `pc[15:8]` takes the byte read at `VEC_ADDR` and `pc[7:0]` takes the byte read at `VEC_ADDR`+1.
- R9: `boot_done` is a one-cycle pulse. It comes in the first cycle in which `pc` holds the new value and `halt` is 0. With the pin released at clock edge r, this is the cycle after edge r+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Raw active-low reset pin, asynchronous to clk |
| mem_rdata | input | 8 | Read data, valid the cycle after its address |
| mem_addr | output | ADDR_W | Vector read address |
| mem_rd | output | 1 | Read strobe for the vector fetch |
| halt | output | 1 | Stops the processor core |
| periph_rst | output | 1 | Broadcast reset for peripheral registers |
| imask | output | 1 | Interrupt mask bit of the condition code register |
| pc | output | 16 | Program counter start value |
| boot_done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
The hardest region to reach from the ports is the boundary of the low-time count. A pulse one cycle shorter than the limit must leave `pc`, `periph_rst` and `boot_done` untouched. A pulse exactly at the limit must start the sequence with the same timing as a long one. A pair of sub-limit pulses with one high cycle between them must not add up. The stimulus drives the pin on falling clock edges, so every low period lasts an exact number of sampling edges. A table of pulse lengths and vector bytes then walks through both sides of the limit and a split pulse. Each accepted entry is followed cycle by cycle through the fetch.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
   localparam int BYTE_W = 8;
   localparam int PC_W   = 2 * BYTE_W;

   typedef enum logic [2:0] {
      ST_HOLD     = 3'd0,
      ST_MASK     = 3'd1,
      ST_FETCH_HI = 3'd2,
      ST_FETCH_LO = 3'd3,
      ST_LOAD     = 3'd4,
      ST_RUN      = 3'd5
   } seq_state_e;
endpackage

// File: rtl/rvs_sync.sv
module rvs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rvs_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk) chain <= {chain[0], d};
      end else begin : g_many
         always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rvs_lowcnt.sv
module rvs_lowcnt #(
   parameter int MIN_LOW = 10
) (
   input  logic clk,
   input  logic pin_low,
   output logic qualified
);
   localparam int CNT_W = $clog2(MIN_LOW + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_LOW);

   logic [CNT_W-1:0] cnt;

   generate
      if (MIN_LOW < 2) begin : g_bad
         $error("rvs_lowcnt: MIN_LOW must be at least 2");
      end
   endgenerate

   // saturating count of consecutive synchronized low cycles
   always_ff @(posedge clk) begin
      if (!pin_low)
         cnt <= '0;
      else if (cnt != LIMIT)
         cnt <= cnt + 1'b1;
   end

   assign qualified = (cnt == LIMIT);

   // a qualified state needs the count held across the sampled low cycles
   p_count_clears_r4: assert property (@(posedge clk)
      (qualified && !$past(qualified)) |-> $past(pin_low));
endmodule

// File: rtl/rvs_seq.sv
module rvs_seq
   import rvs_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int VEC_ADDR = 0,
   parameter bit BIG_END  = 1'b1
) (
   input  logic              clk,
   input  logic              pin_low,
   input  logic              qualified,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              halt,
   output logic              periph_rst,
   output logic              imask,
   output logic [PC_W-1:0]   pc,
   output logic              boot_done
);
   localparam logic [ADDR_W-1:0] ADDR_FIRST  = ADDR_W'(VEC_ADDR);
   localparam logic [ADDR_W-1:0] ADDR_SECOND = ADDR_FIRST + 1'b1;

   seq_state_e        state;
   logic [BYTE_W-1:0] first_q;
   logic [PC_W-1:0]   word;

   generate
      if (ADDR_W < 2 || ADDR_W > 24) begin : g_bad_w
         $error("rvs_seq: ADDR_W out of range");
      end
      if (VEC_ADDR < 0 || VEC_ADDR + 1 >= (1 << ADDR_W)) begin : g_bad_a
         $error("rvs_seq: VEC_ADDR does not fit the address width");
      end
      if (BIG_END) begin : g_be
         assign word = {first_q, mem_rdata};
         p_pc_order_r8: assert property (@(posedge clk) disable iff (pin_low)
            boot_done |-> (pc == {$past(mem_rdata, 2), $past(mem_rdata)}));
      end else begin : g_le
         assign word = {mem_rdata, first_q};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (qualified) begin
         state <= ST_HOLD;
      end else begin
         case (state)
            ST_HOLD:     if (!pin_low) state <= ST_MASK;
            ST_MASK:     state <= ST_FETCH_HI;
            ST_FETCH_HI: state <= ST_FETCH_LO;
            ST_FETCH_LO: state <= ST_LOAD;
            ST_LOAD:     state <= ST_RUN;
            ST_RUN:      state <= ST_RUN;
            default:     state <= ST_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (state == ST_MASK)
         imask <= 1'b1;
      if (state == ST_FETCH_LO)
         first_q <= mem_rdata;
      if (state == ST_LOAD && !qualified)
         pc <= word;
      boot_done <= (state == ST_LOAD) && !qualified;
   end

   assign mem_rd     = (state == ST_FETCH_HI) || (state == ST_FETCH_LO);
   assign mem_addr   = (state == ST_FETCH_LO) ? ADDR_SECOND : ADDR_FIRST;
   assign halt       = pin_low || (state != ST_RUN);
   assign periph_rst = (state == ST_HOLD);

   p_done_single_r9: assert property (@(posedge clk) disable iff (pin_low)
      boot_done |=> !boot_done);
   p_done_releases_r9: assert property (@(posedge clk) disable iff (pin_low)
      boot_done |-> !halt);
   p_mask_first_r6: assert property (@(posedge clk) disable iff (pin_low)
      mem_rd |-> imask);
   p_fetch_order_r7: assert property (@(posedge clk) disable iff (pin_low || qualified)
      (mem_rd && mem_addr == ADDR_FIRST) |=> (mem_rd && mem_addr == ADDR_SECOND));
   p_prst_halts_r5: assert property (@(posedge clk)
      periph_rst |-> (halt && !boot_done));
endmodule

// File: rtl/rst_vec_seq.sv
module rst_vec_seq #(
   parameter int ADDR_W      = 16,
   parameter int VEC_ADDR    = 0,
   parameter int MIN_LOW     = 10,
   parameter int SYNC_STAGES = 2,
   parameter bit BIG_END     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_pin_n,
   input  logic [7:0]        mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              halt,
   output logic              periph_rst,
   output logic              imask,
   output logic [15:0]       pc,
   output logic              boot_done
);
   logic pin_sync;
   logic pin_low;
   logic qualified;

   rvs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (rst_pin_n),
      .q   (pin_sync)
   );

   assign pin_low = !pin_sync;

   rvs_lowcnt #(.MIN_LOW(MIN_LOW)) u_cnt (
      .clk       (clk),
      .pin_low   (pin_low),
      .qualified (qualified)
   );

   rvs_seq #(
      .ADDR_W   (ADDR_W),
      .VEC_ADDR (VEC_ADDR),
      .BIG_END  (BIG_END)
   ) u_seq (
      .clk        (clk),
      .pin_low    (pin_low),
      .qualified  (qualified),
      .mem_rdata  (mem_rdata),
      .mem_addr   (mem_addr),
      .mem_rd     (mem_rd),
      .halt       (halt),
      .periph_rst (periph_rst),
      .imask      (imask),
      .pc         (pc),
      .boot_done  (boot_done)
   );

   // R1: a synchronized low level always halts the core
   p_low_halts_r1: assert property (@(posedge clk)
      (pin_low && $past(pin_low)) |-> halt);
endmodule

// File: tb/sim_rst_vec_seq.sv
`timescale 1ns/1ps
module sim_rst_vec_seq;
   logic        clk = 1'b0;
   logic        rst_pin_n = 1'b0;
   logic [7:0]  mem_rdata = 8'h00;
   logic [15:0] mem_addr;
   logic        mem_rd, halt, periph_rst, imask, boot_done;
   logic [15:0] pc;

   logic [7:0]  mem0 = 8'h00, mem1 = 8'h00;
   int          errors = 0, checks = 0;
   int          done_cnt = 0;
   bit          prst_seen = 1'b0;
   int          cycles = 0;

   always #2.5 clk = ~clk;

   rst_vec_seq u0 (
      .clk(clk), .rst_pin_n(rst_pin_n), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .halt(halt),
      .periph_rst(periph_rst), .imask(imask), .pc(pc), .boot_done(boot_done)
   );

   // synchronous byte memory: data appears the cycle after its address
   always_ff @(posedge clk)
      mem_rdata <= (mem_addr == 16'h0000) ? mem0 :
                   (mem_addr == 16'h0001) ? mem1 : 8'hEE;

   always @(negedge clk) begin
      if (boot_done) done_cnt++;
      if (periph_rst) prst_seen = 1'b1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // fields: pulse length [24:17], byte0 [16:9], byte1 [8:1], accepted [0]
   localparam int NV = 8;
   localparam logic [24:0] TBL [NV] = '{
      {8'd10, 8'h12, 8'h34, 1'b1},
      {8'd9,  8'hAB, 8'hCD, 1'b0},
      {8'd11, 8'h80, 8'h01, 1'b1},
      {8'd3,  8'h55, 8'h66, 1'b0},
      {8'd30, 8'hFF, 8'h00, 1'b1},
      {8'd1,  8'h77, 8'h88, 1'b0},
      {8'd12, 8'h00, 8'hFF, 1'b1},
      {8'd8,  8'h99, 8'h11, 1'b0}
   };

   initial begin
      logic [15:0] prev_pc;

      // power-up: pin held low, then released
      rst_pin_n = 1'b0;
      mem0 = 8'h40; mem1 = 8'h00;
      repeat (20) @(negedge clk);
      chk(halt == 1'b1, "R1 halt at reset", halt, 1);
      chk(periph_rst == 1'b1, "R5 periph_rst held", periph_rst, 1);
      chk(boot_done == 1'b0 && mem_rd == 1'b0, "R9 idle in reset", boot_done, 0);
      rst_pin_n = 1'b1;
      repeat (8) @(negedge clk);
      chk(boot_done == 1'b1, "R9 power-up done", boot_done, 1);
      chk(pc == 16'h4000, "R8 power-up pc", pc, 16'h4000);
      chk(periph_rst == 1'b0, "R5 released", periph_rst, 0);
      repeat (4) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         int  plen;
         bit  acc;
         plen = int'(TBL[v][24:17]);
         acc  = TBL[v][0];
         mem0 = TBL[v][16:9];
         mem1 = TBL[v][8:1];
         prev_pc = pc;
         done_cnt = 0;
         prst_seen = 1'b0;
         rst_pin_n = 1'b0;
         for (int i = 1; i <= plen; i++) begin
            @(negedge clk);
            if (i == 3)
               chk(halt == 1'b1, "R1 halt during low", halt, 1);
            if (i == plen && plen >= 13)
               chk(periph_rst == 1'b1, "R5 periph_rst in long reset", periph_rst, 1);
         end
         rst_pin_n = 1'b1;
         for (int m = 1; m <= 12; m++) begin
            @(negedge clk);
            if (acc) begin
               if (m == 5) begin
                  chk(mem_rd == 1'b1 && mem_addr == 16'h0000, "R7 first read", mem_addr, 0);
                  chk(imask == 1'b1, "R6 mask before fetch", imask, 1);
               end
               if (m == 6)
                  chk(mem_rd == 1'b1 && mem_addr == 16'h0001, "R7 second read", mem_addr, 1);
               if (m == 7)
                  chk(halt == 1'b1, "R1 halt during load", halt, 1);
               if (m == 8) begin
                  chk(boot_done == 1'b1 && halt == 1'b0, "R9 done with release", boot_done, 1);
                  chk(pc == {TBL[v][16:9], TBL[v][8:1]}, "R8 pc byte order", pc,
                      {TBL[v][16:9], TBL[v][8:1]});
               end
               if (m == 9)
                  chk(boot_done == 1'b0, "R9 single pulse", boot_done, 0);
            end
         end
         if (acc) begin
            chk(done_cnt == 1, "R2 accepted once", done_cnt, 1);
            chk(prst_seen == 1'b1, "R5 periph_rst seen", prst_seen, 1);
         end else begin
            chk(done_cnt == 0, "R3 short pulse no sequence", done_cnt, 0);
            chk(prst_seen == 1'b0, "R3 short pulse no periph_rst", prst_seen, 0);
            chk(pc == prev_pc, "R3 pc unchanged", pc, prev_pc);
            chk(halt == 1'b0, "R3 halt released", halt, 0);
         end
      end

      // R4: two sub-limit pulses split by one high cycle must not qualify
      mem0 = 8'hC3; mem1 = 8'h3C;
      prev_pc = pc;
      done_cnt = 0;
      prst_seen = 1'b0;
      rst_pin_n = 1'b0;
      repeat (6) @(negedge clk);
      rst_pin_n = 1'b1;
      @(negedge clk);
      rst_pin_n = 1'b0;
      repeat (6) @(negedge clk);
      rst_pin_n = 1'b1;
      repeat (12) @(negedge clk);
      chk(done_cnt == 0, "R4 split pulse no sequence", done_cnt, 0);
      chk(prst_seen == 1'b0, "R4 split pulse no periph_rst", prst_seen, 0);
      chk(pc == prev_pc, "R4 pc unchanged", pc, prev_pc);
      chk(imask == 1'b1, "R6 mask stays set", imask, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule